// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This unit carries out the one-bit instructions of a small accumulator-based controller. It holds the carry flag (CY) itself. It reaches every other addressable bit through a read/write port to the byte storage of the controller. An operation is a 4-bit operation code plus an 8-bit bit address, presented with a valid strobe. The unit turns the bit address into a byte address and a bit index. It reads the addressed bit and then produces three results: the new CY, an optional single-bit write back to storage, and a take-branch decision for the three bit-conditional jumps. The jump-target arithmetic and the storage array are outside this block.

Each accepted operation uses two register stages. In the first, the mapped address goes out on the read port. In the second, CY, the branch flag and any write request become visible together with a done pulse. An operation may be accepted on every cycle. A write that is still pending is forwarded to the operation behind it, so a back-to-back sequence on the same bit behaves as if the operations ran one at a time. Three status flags of the flag register (parity, overflow, auxiliary carry) are read-only to this unit. The bit address that names CY inside the flag register is served from the internal flag, not from storage.

Top module: `bitproc_unit`

## Requirements
- R1: Operation codes 1, 2 and 3 clear, set and complement CY respectively; none of them writes storage and none branches.
- R2: Operation codes 4, 5 and 6 write 0, 1 and the complement of the current bit value to the addressed bit, and leave CY unchanged.
- R3: Operation codes 7, 8, 9 and 10 set CY to CY AND bit, CY AND NOT bit, CY OR bit and CY OR NOT bit respectively, without writing storage.
- R4: Operation code 11 copies the addressed bit into CY. Operation code 12 writes CY into the addressed bit.
- R5: A write aimed at bit addresses D0h, D2h or D6h (flag byte D0h, bit indexes 0, 2, 6) is dropped: write enable stays low and storage is not changed. The rest of the operation still completes.
- R6: Bit address D7h is CY itself. Reads of it return CY, writes to it update CY, and it never raises a storage write.
- R7: Operation code 13 asserts take_branch when the bit is 1. Operation code 14 asserts take_branch when the bit is 0. Neither writes storage.
- R8: Operation code 15 asserts take_branch and writes 0 to the bit when the bit is 1. When the bit is 0 it neither branches nor writes.
- R9: A bit address below 80h maps to byte 20h + (address >> 3), bit index address[2:0].
- R10: A bit address of 80h or above maps to byte address & F8h, bit index address[2:0].
- R11: An operation issued in the cycle right after one that writes the same bit sees the written value.
- R12: After synchronous reset, CY, done, take_branch, wr_en and rd_req are all 0.
- R13: Every accepted operation gives exactly one done pulse two clock edges after acceptance. wr_en and take_branch are only high together with done. Every storage write is a byte read-modify-write request that changes only the addressed bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation accepted this cycle |
| op_code | input | 4 | Operation code (see R1 to R8) |
| op_bit_addr | input | 8 | Bit address of the operand |
| rd_req | output | 1 | Storage read of the mapped bit is wanted |
| rd_byte_addr | output | 8 | Byte address for the read |
| rd_bit_idx | output | 3 | Bit index within the read byte |
| rd_bit | input | 1 | Bit value returned by storage in the same cycle |
| wr_en | output | 1 | Byte read-modify-write request for one bit |
| wr_byte_addr | output | 8 | Byte address of the write |
| wr_bit_idx | output | 3 | Bit index of the write |
| wr_bit | output | 1 | Value written to that bit |
| cy | output | 1 | Carry flag |
| done | output | 1 | Operation result valid |
| take_branch | output | 1 | Branch condition met, valid with done |

## Verification
The bound assertions watch, on every cycle, that writes never reach the locked flag bits or the CY alias. They also check that write and branch strobes appear only with done, that the test-and-clear jump only ever writes 0, that CY-clear leaves CY low, and that both address regions map correctly. Whether each logic function gives the right CY, whether forwarding gives in-order results, and whether the storage image ends up correct can only be shown by the bench. It runs a reference model over random operation streams and directed corner cases, then compares the full byte image at the end.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_CLR_C  = 4'd1,
    OP_SET_C  = 4'd2,
    OP_CPL_C  = 4'd3,
    OP_CLR_B  = 4'd4,
    OP_SET_B  = 4'd5,
    OP_CPL_B  = 4'd6,
    OP_AND_B  = 4'd7,
    OP_AND_NB = 4'd8,
    OP_OR_B   = 4'd9,
    OP_OR_NB  = 4'd10,
    OP_LD_C   = 4'd11,
    OP_ST_C   = 4'd12,
    OP_JB     = 4'd13,
    OP_JNB    = 4'd14,
    OP_JBC    = 4'd15
  } bop_e;

  // Operations from OP_CLR_B upward touch an addressed bit.
  function automatic logic op_uses_bit(bop_e op);
    return (op >= OP_CLR_B);
  endfunction

endpackage

// File: rtl/bitproc_addr_map.sv
module bitproc_addr_map #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned IDX_W     = 3,
  parameter logic [7:0]  RAM_BASE  = 8'h20,
  parameter logic [7:0]  FLAG_BYTE = 8'hD0,
  parameter logic [7:0]  PROT_MASK = 8'h45,
  parameter int unsigned CY_IDX    = 7
) (
  input  logic [ADDR_W-1:0] bit_addr,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              is_cy_alias,
  output logic              is_locked
);
  localparam logic [ADDR_W-1:0] IDX_MASK = ADDR_W'((1 << IDX_W) - 1);

  logic hi_region;
  logic on_flag_byte;

  always_comb begin
    hi_region    = bit_addr[ADDR_W-1];
    bit_idx      = bit_addr[IDX_W-1:0];
    if (hi_region) begin
      byte_addr = bit_addr & ~IDX_MASK;
    end else begin
      byte_addr = ADDR_W'(RAM_BASE) + (bit_addr >> IDX_W);
    end
    on_flag_byte = hi_region && (byte_addr == ADDR_W'(FLAG_BYTE));
    is_cy_alias  = on_flag_byte && (bit_idx == IDX_W'(CY_IDX));
    is_locked    = on_flag_byte && PROT_MASK[bit_idx];
  end

endmodule

// File: rtl/bitproc_alu.sv
module bitproc_alu
  import bitproc_pkg::*;
(
  input  bop_e op,
  input  logic cy_in,
  input  logic bval,
  output logic cy_out,
  output logic wr_need,
  output logic wr_val,
  output logic take
);
  always_comb begin
    cy_out  = cy_in;
    wr_need = 1'b0;
    wr_val  = 1'b0;
    take    = 1'b0;
    unique case (op)
      OP_CLR_C:  cy_out = 1'b0;
      OP_SET_C:  cy_out = 1'b1;
      OP_CPL_C:  cy_out = ~cy_in;
      OP_CLR_B:  begin wr_need = 1'b1; wr_val = 1'b0;  end
      OP_SET_B:  begin wr_need = 1'b1; wr_val = 1'b1;  end
      OP_CPL_B:  begin wr_need = 1'b1; wr_val = ~bval; end
      OP_AND_B:  cy_out = cy_in & bval;
      OP_AND_NB: cy_out = cy_in & ~bval;
      OP_OR_B:   cy_out = cy_in | bval;
      OP_OR_NB:  cy_out = cy_in | ~bval;
      OP_LD_C:   cy_out = bval;
      OP_ST_C:   begin wr_need = 1'b1; wr_val = cy_in; end
      OP_JB:     take = bval;
      OP_JNB:    take = ~bval;
      OP_JBC:    begin take = bval; wr_need = bval; wr_val = 1'b0; end
      default:   cy_out = cy_in;
    endcase
  end
endmodule

// File: rtl/bitproc_unit.sv
module bitproc_unit
  import bitproc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned OP_W      = 4,
  parameter logic [7:0]  RAM_BASE  = 8'h20,
  parameter logic [7:0]  FLAG_BYTE = 8'hD0,
  parameter logic [7:0]  PROT_MASK = 8'h45,
  parameter int unsigned CY_IDX    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [ADDR_W-1:0] op_bit_addr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_byte_addr,
  output logic [IDX_W-1:0]  rd_bit_idx,
  input  logic              rd_bit,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_byte_addr,
  output logic [IDX_W-1:0]  wr_bit_idx,
  output logic              wr_bit,
  output logic              cy,
  output logic              done,
  output logic              take_branch
);
  // Stage 0: combinational address mapping of the incoming operation
  logic [ADDR_W-1:0] m_byte;
  logic [IDX_W-1:0]  m_idx;
  logic              m_alias;
  logic              m_locked;
  bop_e              in_op;

  assign in_op = bop_e'(op_code);

  bitproc_addr_map #(
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .RAM_BASE (RAM_BASE),
    .FLAG_BYTE(FLAG_BYTE),
    .PROT_MASK(PROT_MASK),
    .CY_IDX   (CY_IDX)
  ) map_i (
    .bit_addr   (op_bit_addr),
    .byte_addr  (m_byte),
    .bit_idx    (m_idx),
    .is_cy_alias(m_alias),
    .is_locked  (m_locked)
  );

  // Stage A: registered read request
  logic a_valid;
  bop_e a_op;
  logic a_alias;
  logic a_locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid      <= 1'b0;
      a_op         <= OP_NOP;
      a_alias      <= 1'b0;
      a_locked     <= 1'b0;
      rd_req       <= 1'b0;
      rd_byte_addr <= '0;
      rd_bit_idx   <= '0;
    end else begin
      a_valid      <= op_valid;
      a_op         <= op_valid ? in_op : OP_NOP;
      a_alias      <= m_alias;
      a_locked     <= m_locked;
      rd_req       <= op_valid && op_uses_bit(in_op) && !m_alias;
      rd_byte_addr <= m_byte;
      rd_bit_idx   <= m_idx;
    end
  end

  // Operand selection: CY alias, pending write, or storage
  logic fwd_hit;
  logic bval;

  always_comb begin
    fwd_hit = wr_en && (wr_byte_addr == rd_byte_addr) && (wr_bit_idx == rd_bit_idx);
    if (a_alias) begin
      bval = cy;
    end else if (fwd_hit) begin
      bval = wr_bit;
    end else begin
      bval = rd_bit;
    end
  end

  logic alu_cy;
  logic alu_wr;
  logic alu_wval;
  logic alu_take;

  bitproc_alu alu_i (
    .op     (a_op),
    .cy_in  (cy),
    .bval   (bval),
    .cy_out (alu_cy),
    .wr_need(alu_wr),
    .wr_val (alu_wval),
    .take   (alu_take)
  );

  // Stage B: registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      done         <= 1'b0;
      take_branch  <= 1'b0;
      wr_en        <= 1'b0;
      wr_byte_addr <= '0;
      wr_bit_idx   <= '0;
      wr_bit       <= 1'b0;
      cy           <= 1'b0;
    end else begin
      done         <= a_valid;
      take_branch  <= a_valid && alu_take;
      wr_en        <= a_valid && alu_wr && !a_alias && !a_locked;
      wr_byte_addr <= rd_byte_addr;
      wr_bit_idx   <= rd_bit_idx;
      wr_bit       <= alu_wval;
      if (a_valid) begin
        cy <= (a_alias && alu_wr) ? alu_wval : alu_cy;
      end
    end
  end

endmodule

// File: rtl/bitproc_unit_chk.sv
module bitproc_unit_chk
  import bitproc_pkg::*;
#(
  parameter logic [7:0]  RAM_BASE  = 8'h20,
  parameter logic [7:0]  FLAG_BYTE = 8'hD0,
  parameter logic [7:0]  PROT_MASK = 8'h45,
  parameter int unsigned CY_IDX    = 7
) (
  input logic       clk,
  input logic       rst,
  input logic       op_valid,
  input logic [3:0] op_code,
  input logic [7:0] op_bit_addr,
  input logic       rd_req,
  input logic [7:0] rd_byte_addr,
  input logic [2:0] rd_bit_idx,
  input logic       rd_bit,
  input logic       wr_en,
  input logic [7:0] wr_byte_addr,
  input logic [2:0] wr_bit_idx,
  input logic       wr_bit,
  input logic       cy,
  input logic       done,
  input logic       take_branch
);
  p_wr_with_done_r13: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> done);

  p_take_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    take_branch |-> done);

  p_read_then_done_r13: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> done);

  p_flags_locked_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !((wr_byte_addr == FLAG_BYTE) && PROT_MASK[wr_bit_idx]));

  p_cy_alias_no_store_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !((wr_byte_addr == FLAG_BYTE) && (wr_bit_idx == 3'(CY_IDX))));

  p_jbc_writes_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(op_valid, 2) && ($past(op_code, 2) == OP_JBC)) |-> !wr_bit);

  p_clr_c_low_r1: assert property (@(posedge clk) disable iff (rst)
    (done && $past(op_valid, 2) && ($past(op_code, 2) == OP_CLR_C)) |-> !cy);

  p_low_map_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !$past(op_bit_addr[7])) |->
      ((rd_byte_addr == 8'(RAM_BASE + 8'($past(op_bit_addr) >> 3)))
       && (rd_bit_idx == $past(op_bit_addr[2:0]))));

  p_high_map_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_req && $past(op_bit_addr[7])) |->
      ((rd_byte_addr == {$past(op_bit_addr[7:3]), 3'b000})
       && (rd_bit_idx == $past(op_bit_addr[2:0]))));

endmodule

bind bitproc_unit bitproc_unit_chk #(
  .RAM_BASE (RAM_BASE),
  .FLAG_BYTE(FLAG_BYTE),
  .PROT_MASK(PROT_MASK),
  .CY_IDX   (CY_IDX)
) chk_i (.*);

// File: tb/bitproc_unit_tb_top.sv
module bitproc_unit_tb_top;
  import bitproc_pkg::*;

  localparam int MAXOPS = 1024;
  localparam int WATCHDOG = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] op_bit_addr = 8'd0;
  logic       rd_req;
  logic [7:0] rd_byte_addr;
  logic [2:0] rd_bit_idx;
  logic       rd_bit;
  logic       wr_en;
  logic [7:0] wr_byte_addr;
  logic [2:0] wr_bit_idx;
  logic       wr_bit;
  logic       cy;
  logic       done;
  logic       take_branch;

  always #2 clk = ~clk;

  bitproc_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_bit_addr(op_bit_addr), .rd_req(rd_req), .rd_byte_addr(rd_byte_addr),
    .rd_bit_idx(rd_bit_idx), .rd_bit(rd_bit), .wr_en(wr_en),
    .wr_byte_addr(wr_byte_addr), .wr_bit_idx(wr_bit_idx), .wr_bit(wr_bit),
    .cy(cy), .done(done), .take_branch(take_branch)
  );

  // Storage model driven only by the DUT
  logic [7:0] mem [256];
  assign rd_bit = mem[rd_byte_addr][rd_bit_idx];
  always @(posedge clk) if (wr_en) mem[wr_byte_addr][wr_bit_idx] <= wr_bit;

  // Reference model state
  logic [7:0] ref_mem [256];
  logic       ref_cy;
  int checks = 0;
  int errors = 0;
  int n_issued = 0;
  int n_done = 0;
  int cycles = 0;
  logic last_wr = 1'b0;
  logic [7:0] last_wbyte = 8'd0;
  logic [2:0] last_widx = 3'd0;

  logic       e_cy [MAXOPS];
  logic       e_take [MAXOPS];
  logic       e_wr [MAXOPS];
  logic [7:0] e_wbyte [MAXOPS];
  logic [2:0] e_widx [MAXOPS];
  logic       e_wbit [MAXOPS];
  string      e_tag [MAXOPS];

  function automatic logic [7:0] ref_byte(logic [7:0] a);
    return (a < 8'h80) ? 8'(8'h20 + a / 8) : (a & 8'hF8);
  endfunction

  function automatic logic is_locked(logic [7:0] a);
    return (a == 8'hD0) || (a == 8'hD2) || (a == 8'hD6);
  endfunction

  function automatic string tag_of(logic [3:0] op, logic [7:0] a);
    if (a == 8'hD7 && op >= 4) return "R6";
    if (is_locked(a) && (op inside {4, 5, 6, 12, 15})) return "R5";
    case (op)
      1, 2, 3:        return "R1";
      4, 5, 6:        return "R2";
      7, 8, 9, 10:    return "R3";
      11, 12:         return "R4";
      13, 14:         return "R7";
      15:             return "R8";
      default:        return "R13";
    endcase
  endfunction

  task automatic issue(input logic [3:0] op, input logic [7:0] a);
    logic b, ncy, wneed, wval, tk, alias_b, storew;
    logic [7:0] by;
    logic [2:0] ix;
    by = ref_byte(a);
    ix = a[2:0];
    alias_b = (a == 8'hD7);
    b = alias_b ? ref_cy : ref_mem[by][ix];
    ncy = ref_cy; wneed = 1'b0; wval = 1'b0; tk = 1'b0;
    case (op)
      4'd1: ncy = 1'b0;
      4'd2: ncy = 1'b1;
      4'd3: ncy = ~ref_cy;
      4'd4: begin wneed = 1'b1; wval = 1'b0; end
      4'd5: begin wneed = 1'b1; wval = 1'b1; end
      4'd6: begin wneed = 1'b1; wval = ~b; end
      4'd7: ncy = ref_cy & b;
      4'd8: ncy = ref_cy & ~b;
      4'd9: ncy = ref_cy | b;
      4'd10: ncy = ref_cy | ~b;
      4'd11: ncy = b;
      4'd12: begin wneed = 1'b1; wval = ref_cy; end
      4'd13: tk = b;
      4'd14: tk = ~b;
      4'd15: begin tk = b; wneed = b; wval = 1'b0; end
      default: ;
    endcase
    storew = wneed && !alias_b && !is_locked(a);
    if (alias_b && wneed) ncy = wval;
    e_tag[n_issued] = (op >= 4 && !alias_b && last_wr && last_wbyte == by && last_widx == ix)
                      ? "R11" : tag_of(op, a);
    e_cy[n_issued] = ncy;
    e_take[n_issued] = tk;
    e_wr[n_issued] = storew;
    e_wbyte[n_issued] = by;
    e_widx[n_issued] = ix;
    e_wbit[n_issued] = wval;
    ref_cy = ncy;
    if (storew) ref_mem[by][ix] = wval;
    last_wr = storew; last_wbyte = by; last_widx = ix;
    n_issued++;
    @(negedge clk);
    op_valid = 1'b1; op_code = op; op_bit_addr = a;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_valid = 1'b0;
      last_wr = 1'b0;
    end
  endtask

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Result monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst && done) begin
      int k;
      k = n_done;
      check({cy, take_branch} == {e_cy[k], e_take[k]}, e_tag[k], "cy/take",
            {30'd0, cy, take_branch}, {30'd0, e_cy[k], e_take[k]});
      if (e_wr[k])
        check(wr_en && wr_byte_addr == e_wbyte[k] && wr_bit_idx == e_widx[k] && wr_bit == e_wbit[k],
              (e_wbyte[k] < 8'h80) ? "R9" : "R10", "write fields",
              {20'd0, wr_en, wr_byte_addr, wr_bit_idx}, {20'd0, 1'b1, e_wbyte[k], e_widx[k]});
      else
        check(!wr_en, e_tag[k], "no write expected", {31'd0, wr_en}, 32'd0);
      n_done++;
    end
  end

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL R13 watchdog actual=%0d expected=%0d", cycles, 0);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'($urandom);
      ref_mem[i] = mem[i];
    end
    ref_cy = 1'b0;
    repeat (4) @(negedge clk);
    // R12: reset state
    check({cy, done, take_branch, wr_en, rd_req} == 5'd0, "R12", "reset outputs",
          {27'd0, cy, done, take_branch, wr_en, rd_req}, 32'd0);
    rst = 1'b0;
    idle(2);

    // Directed corners
    issue(4'd2, 8'h00);            // R1 set CY
    issue(4'd12, 8'h00);           // R4 store CY into 20h bit0
    issue(4'd13, 8'h00);           // R11 forwarded JB
    issue(4'd15, 8'h00);           // R11/R8 JBC on a set bit clears it
    issue(4'd15, 8'h00);           // R8 bit now 0: no branch, no write
    issue(4'd5, 8'h7F);            // R9 highest low bit -> 2Fh bit7
    issue(4'd4, 8'h80);            // R10 lowest high bit -> 80h bit0
    issue(4'd6, 8'hFF);            // R10 F8h bit7
    issue(4'd5, 8'hD0);            // R5 locked parity
    issue(4'd6, 8'hD2);            // R5 locked overflow
    issue(4'd12, 8'hD6);           // R5 locked aux carry
    issue(4'd4, 8'hD7);            // R6 clear CY through alias
    issue(4'd14, 8'hD7);           // R6 read alias
    issue(4'd5, 8'hD7);            // R6 set CY through alias
    issue(4'd8, 8'h80);            // R3 AND NOT
    issue(4'd10, 8'h80);           // R3 OR NOT
    idle(3);

    // Random stream
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      int sel;
      sel = $urandom % 8;
      case (sel)
        0, 1, 2: a = 8'($urandom % 128);
        3, 4:    a = 8'(8'h80 + ($urandom % 128));
        5:       a = 8'hD7;
        6:       a = 8'hD0 + 8'(2 * ($urandom % 4));
        default: a = op_bit_addr;
      endcase
      issue(4'($urandom % 16), a);
      if ($urandom % 6 == 0) idle(1);
    end
    idle(4);

    // R13: one done per operation
    check(n_done == n_issued, "R13", "done count", n_done, n_issued);
    // R13/R5: final storage image, only addressed bits changed
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
      check(bad == 0, "R13", "storage image mismatches", bad, 0);
    end
    check(ref_mem[8'hD0] == mem[8'hD0], "R5", "flag byte", mem[8'hD0], ref_mem[8'hD0]);
    summary();
    $finish;
  end

endmodule